// File: doc/BRIEF.md
# Firmware Image CRC Verifier

This block checks a firmware image as it streams in, one byte per clock, on a valid/last handshake. A fixed-size header at the front of every image is skipped. The two bytes at the tail are held back as the stored check value. Every byte in between is payload and goes through a reflected 16-bit CRC. When the last byte is accepted, the block compares the inverted CRC with the stored value. In the next cycle it gives a one-cycle verdict with a status code, and it reports both the computed and the received check value.

Images may follow each other with no idle cycles. Idle cycles (valid low) may also sit anywhere inside an image. A start pulse drops a partly received image, so that a new image can begin at once. Images too short to hold a header, a trailer and at least one payload byte raise an error strobe. An image whose payload is empty has a status code of its own.

Top module: `fwcrc_verifier`

## Requirements
- R1: The first 64 bytes of every image do not affect the computed value or the verdict.
- R2: The last two bytes form the stored check value: the byte before last is the low byte and the last byte is the high byte. They are shown on `rxCheck` and are not fed into the payload CRC.
- R3: The payload CRC shifts toward the LSB with polynomial 0x8408, starts from 0xFFFF and is inverted at the end. The payload ASCII "123456789" gives `calcCheck` = 0x906E.
- R4: If the computed and stored values match, `pass` is high and `status` is 0x0000. If they differ, `pass` is low and `status` is 0x0001.
- R5: `done`, together with `pass` and `malformed`, is high for exactly one cycle, in the cycle after the beat carrying `inLast`. `status`, `calcCheck` and `rxCheck` keep their values until the next image ends.
- R6: An image of exactly 66 bytes (empty payload) reports `status` 0xD00A, `malformed` high, `pass` low, `calcCheck` 0 and the trailer on `rxCheck`.
- R7: An image shorter than 66 bytes reports `status` 0xD00B, `malformed` high, `pass` low, and 0 on `calcCheck` and `rxCheck`.
- R8: A `start` pulse discards any partial image. A byte that is valid in the same cycle as `start` is byte 0 of the new image.
- R9: Images may follow each other with no idle cycle between them, and cycles with `inValid` low inside an image are ignored.
- R10: After reset, `done`, `pass` and `malformed` are low and `status`, `calcCheck` and `rxCheck` are 0.
- R11: The variant that checks the residue gives the same verdicts. It runs the CRC over the payload plus both trailer bytes, low byte first, and expects 0xF0B8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Drops any partial image |
| inValid | input | 1 | A byte is present on inData |
| inData | input | 8 | Image byte |
| inLast | input | 1 | Marks the final byte of an image |
| done | output | 1 | One-cycle end-of-image strobe |
| pass | output | 1 | One-cycle strobe for a good image |
| status | output | 16 | Result code of the last image |
| calcCheck | output | 16 | Computed check value |
| rxCheck | output | 16 | Stored check value from the trailer |
| malformed | output | 1 | One-cycle strobe for a short image |

## Verification
Payload lengths from 1 to 40 bytes are swept with correct trailers, and then again with one flipped payload bit. These two sweeps separate a true CRC from one that ignores some bytes or bits. A standard nine-byte vector pins down the polynomial, the preset, the bit order and the final inversion. Varying only the header separates a correct skip from an off-by-one in the header count. Every total length from 1 to 66 is swept to find the exact edges of the empty-payload and short-image codes. Gapped streams, back-to-back images and start pulses (both in an idle cycle and on a byte) show that partial state is neither lost nor kept by mistake. The residue variant runs in parallel as a second instance.

// File: rtl/fwcrc_pkg.sv
package fwcrc_pkg;

  localparam logic [15:0] STAT_OK       = 16'h0000;
  localparam logic [15:0] STAT_MISMATCH = 16'h0001;
  localparam logic [15:0] STAT_EMPTY    = 16'hD00A;
  localparam logic [15:0] STAT_SHORT    = 16'hD00B;

  typedef struct packed {
    logic clear;     // drop partial image state
    logic take;      // byte past header enters the hold-back window
    logic feed;      // oldest held byte enters the CRC
    logic finish;    // final byte of the image this cycle
    logic empty;     // image ends with no payload
    logic tooShort;  // image ends before the trailer is complete
  } ctrlStrobes_t;

endpackage

// File: rtl/fwcrc_step.sv
module fwcrc_step #(
  parameter int DATA_W = 8,
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h8408
) (
  input  logic [CRC_W-1:0]  crcIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [CRC_W-1:0]  crcOut
);

  logic [CRC_W-1:0] stage [0:DATA_W];

  assign stage[0] = crcIn ^ {{(CRC_W-DATA_W){1'b0}}, dataIn};

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign stage[g+1] = stage[g][0] ? ((stage[g] >> 1) ^ POLY) : (stage[g] >> 1);
  end

  assign crcOut = stage[DATA_W];

endmodule

// File: rtl/fwcrc_ctrl.sv
module fwcrc_ctrl
  import fwcrc_pkg::*;
#(
  parameter int HDR_BYTES = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         inValid,
  input  logic         inLast,
  output ctrlStrobes_t strb
);

  localparam int MIN_LEN = HDR_BYTES + 3;
  localparam int CW = $clog2(MIN_LEN + 1);
  localparam logic [CW-1:0] IDX_PAY0  = CW'(HDR_BYTES);
  localparam logic [CW-1:0] IDX_EMPTY = CW'(HDR_BYTES + 1);
  localparam logic [CW-1:0] IDX_FEED  = CW'(HDR_BYTES + 2);
  localparam logic [CW-1:0] IDX_SAT   = CW'(MIN_LEN);

  logic [CW-1:0] byteIdx;
  logic [CW-1:0] effIdx;

  // a start in the same cycle as a byte makes that byte index zero
  assign effIdx = start ? '0 : byteIdx;

  always_comb begin
    strb.clear    = start;
    strb.take     = inValid && (effIdx >= IDX_PAY0);
    strb.feed     = inValid && (effIdx >= IDX_FEED);
    strb.finish   = inValid && inLast;
    strb.empty    = (effIdx == IDX_EMPTY);
    strb.tooShort = (effIdx < IDX_EMPTY);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byteIdx <= '0;
    end else if (inValid) begin
      if (inLast) begin
        byteIdx <= '0;
      end else if (effIdx != IDX_SAT) begin
        byteIdx <= effIdx + CW'(1);
      end else begin
        byteIdx <= effIdx;
      end
    end else if (start) begin
      byteIdx <= '0;
    end
  end

endmodule

// File: rtl/fwcrc_dp.sv
module fwcrc_dp
  import fwcrc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [2*DATA_W-1:0] POLY = 16'h8408,
  parameter logic [2*DATA_W-1:0] PRESET = 16'hFFFF,
  parameter logic [2*DATA_W-1:0] XOR_OUT = 16'hFFFF,
  parameter logic [2*DATA_W-1:0] RESIDUE = 16'hF0B8,
  parameter bit USE_RESIDUE = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ctrlStrobes_t          strb,
  input  logic [DATA_W-1:0]     inData,
  output logic                  done,
  output logic                  pass,
  output logic [15:0]           status,
  output logic [2*DATA_W-1:0]   calcCheck,
  output logic [2*DATA_W-1:0]   rxCheck,
  output logic                  malformed
);

  localparam int CRC_W = 2 * DATA_W;

  logic [CRC_W-1:0] crcReg, crcBase, crcFed, crcNext, calcWord;
  logic [CRC_W-1:0] holdReg, holdBase, holdNext;
  logic             matchOk;

  assign crcBase  = strb.clear ? PRESET : crcReg;
  assign holdBase = strb.clear ? '0 : holdReg;

  fwcrc_step #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) u_feedStep (
    .crcIn (crcBase),
    .dataIn(holdBase[DATA_W-1:0]),
    .crcOut(crcFed)
  );

  assign crcNext  = strb.feed ? crcFed : crcBase;
  assign holdNext = strb.take ? {inData, holdBase[CRC_W-1:DATA_W]} : holdBase;
  assign calcWord = crcNext ^ XOR_OUT;

  if (USE_RESIDUE) begin : g_residue
    logic [CRC_W-1:0] resLo, resHi;
    fwcrc_step #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) u_resLo (
      .crcIn (crcNext),
      .dataIn(holdNext[DATA_W-1:0]),
      .crcOut(resLo)
    );
    fwcrc_step #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) u_resHi (
      .crcIn (resLo),
      .dataIn(holdNext[CRC_W-1:DATA_W]),
      .crcOut(resHi)
    );
    assign matchOk = (resHi == RESIDUE);
  end else begin : g_compare
    assign matchOk = (calcWord == holdNext);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crcReg    <= PRESET;
      holdReg   <= '0;
      done      <= 1'b0;
      pass      <= 1'b0;
      malformed <= 1'b0;
      status    <= STAT_OK;
      calcCheck <= '0;
      rxCheck   <= '0;
    end else begin
      done      <= strb.finish;
      pass      <= 1'b0;
      malformed <= 1'b0;
      if (strb.finish) begin
        crcReg  <= PRESET;
        holdReg <= '0;
        if (strb.tooShort) begin
          status    <= STAT_SHORT;
          calcCheck <= '0;
          rxCheck   <= '0;
          malformed <= 1'b1;
        end else if (strb.empty) begin
          status    <= STAT_EMPTY;
          calcCheck <= '0;
          rxCheck   <= holdNext;
          malformed <= 1'b1;
        end else begin
          status    <= matchOk ? STAT_OK : STAT_MISMATCH;
          pass      <= matchOk;
          calcCheck <= calcWord;
          rxCheck   <= holdNext;
        end
      end else begin
        crcReg  <= crcNext;
        holdReg <= holdNext;
      end
    end
  end

endmodule

// File: rtl/fwcrc_verifier.sv
module fwcrc_verifier
  import fwcrc_pkg::*;
#(
  parameter int HDR_BYTES = 64,
  parameter int DATA_W = 8,
  parameter logic [2*DATA_W-1:0] POLY = 16'h8408,
  parameter logic [2*DATA_W-1:0] PRESET = 16'hFFFF,
  parameter logic [2*DATA_W-1:0] XOR_OUT = 16'hFFFF,
  parameter logic [2*DATA_W-1:0] RESIDUE = 16'hF0B8,
  parameter bit USE_RESIDUE = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                inValid,
  input  logic [DATA_W-1:0]   inData,
  input  logic                inLast,
  output logic                done,
  output logic                pass,
  output logic [15:0]         status,
  output logic [2*DATA_W-1:0] calcCheck,
  output logic [2*DATA_W-1:0] rxCheck,
  output logic                malformed
);

  ctrlStrobes_t strb;

  fwcrc_ctrl #(.HDR_BYTES(HDR_BYTES)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .inValid(inValid),
    .inLast (inLast),
    .strb   (strb)
  );

  fwcrc_dp #(
    .DATA_W(DATA_W), .POLY(POLY), .PRESET(PRESET), .XOR_OUT(XOR_OUT),
    .RESIDUE(RESIDUE), .USE_RESIDUE(USE_RESIDUE)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .inData   (inData),
    .done     (done),
    .pass     (pass),
    .status   (status),
    .calcCheck(calcCheck),
    .rxCheck  (rxCheck),
    .malformed(malformed)
  );

endmodule

// File: rtl/fwcrc_verifier_chk.sv
module fwcrc_verifier_chk (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic        inLast,
  input logic        done,
  input logic        pass,
  input logic [15:0] status,
  input logic [15:0] calcCheck,
  input logic [15:0] rxCheck,
  input logic        malformed
);

  // R5
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(inValid && inLast));

  // R5
  pass_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    (pass || malformed) |-> done);

  // R4
  pass_match_chk: assert property (@(posedge clk) disable iff (rst)
    pass |-> (status == 16'h0000 && calcCheck == rxCheck && !malformed));

  // R4
  verdict_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !malformed) |-> (pass == (calcCheck == rxCheck)));

  // R6
  empty_code_chk: assert property (@(posedge clk) disable iff (rst)
    (done && status == 16'hD00A) |-> (malformed && calcCheck == 16'h0000));

  // R7
  malformed_code_chk: assert property (@(posedge clk) disable iff (rst)
    malformed |-> (status == 16'hD00A || status == 16'hD00B));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!done && !pass && !malformed && status == 16'h0000));

endmodule

bind fwcrc_verifier fwcrc_verifier_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inLast   (inLast),
  .done     (done),
  .pass     (pass),
  .status   (status),
  .calcCheck(calcCheck),
  .rxCheck  (rxCheck),
  .malformed(malformed)
);

// File: tb/test_fwcrc_verifier.sv
module test_fwcrc_verifier;

  localparam int HDR = 64;
  localparam int MAXLEN = HDR + 2 + 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inData = '0;
  logic inLast = 1'b0;

  logic done, pass, malformed;
  logic [15:0] status, calcCheck, rxCheck;
  logic doneR, passR, malR;
  logic [15:0] statusR, calcR, rxR;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;

  logic [7:0] img [0:MAXLEN-1];
  int imgLen;

  always #4 clk = ~clk;

  fwcrc_verifier i_fwcrc_verifier (
    .clk(clk), .rst(rst), .start(start), .inValid(inValid), .inData(inData),
    .inLast(inLast), .done(done), .pass(pass), .status(status),
    .calcCheck(calcCheck), .rxCheck(rxCheck), .malformed(malformed)
  );

  fwcrc_verifier #(.USE_RESIDUE(1'b1)) i_fwcrc_verifier_res (
    .clk(clk), .rst(rst), .start(start), .inValid(inValid), .inData(inData),
    .inLast(inLast), .done(doneR), .pass(passR), .status(statusR),
    .calcCheck(calcR), .rxCheck(rxR), .malformed(malR)
  );

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      finishRun();
    end
  end

  function automatic logic [15:0] stepRef(logic [15:0] c, logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  function automatic logic [15:0] payloadCheck(int payLen);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < payLen; i++) c = stepRef(c, img[HDR+i]);
    return ~c;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // header and payload from seeds, trailer holds the correct check value
  task automatic buildImage(input int payLen, input int hdrSeed, input int paySeed);
    logic [15:0] cv;
    for (int i = 0; i < HDR; i++) img[i] = 8'((hdrSeed * 37 + i * 11) ^ (i >> 3));
    for (int i = 0; i < payLen; i++) img[HDR+i] = 8'(paySeed * 29 + i * 13 + (i >> 2) * 7);
    cv = payloadCheck(payLen);
    img[HDR+payLen]   = cv[7:0];
    img[HDR+payLen+1] = cv[15:8];
    imgLen = HDR + payLen + 2;
  endtask

  task automatic sendImage(input bit gaps, input bit withStart);
    for (int i = 0; i < imgLen; i++) begin
      if (gaps && (i % 3 == 1)) begin
        inValid = 1'b0;
        inLast = 1'b0;
        @(negedge clk);
      end
      inValid = 1'b1;
      inData = img[i];
      inLast = (i == imgLen - 1);
      start = withStart && (i == 0);
      @(negedge clk);
    end
    inValid = 1'b0;
    inLast = 1'b0;
    start = 1'b0;
  endtask

  task automatic expectResult(input string req, input logic [15:0] eCalc,
                              input logic [15:0] eRx, input logic ePass,
                              input logic [15:0] eStat, input logic eMal);
    chk(req, "done", 32'(done), 32'(1'b1));
    chk(req, "pass", 32'(pass), 32'(ePass));
    chk(req, "status", 32'(status), 32'(eStat));
    chk(req, "calcCheck", 32'(calcCheck), 32'(eCalc));
    chk(req, "rxCheck", 32'(rxCheck), 32'(eRx));
    chk(req, "malformed", 32'(malformed), 32'(eMal));
    // R11 residue variant agrees on the verdict
    chk("R11", "residue pass", 32'(passR), 32'(ePass));
    chk("R11", "residue status", 32'(statusR), 32'(eStat));
  endtask

  initial begin
    logic [15:0] cv, rxv;
    string digits;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state
    chk("R10", "done", 32'(done), 0);
    chk("R10", "pass", 32'(pass), 0);
    chk("R10", "malformed", 32'(malformed), 0);
    chk("R10", "status", 32'(status), 0);
    chk("R10", "calcCheck", 32'(calcCheck), 0);
    chk("R10", "rxCheck", 32'(rxCheck), 0);

    // R3 standard vector
    digits = "123456789";
    buildImage(9, 3, 0);
    for (int i = 0; i < 9; i++) img[HDR+i] = digits[i];
    img[HDR+9] = 8'h6E;
    img[HDR+10] = 8'h90;
    sendImage(1'b0, 1'b0);
    expectResult("R3", 16'h906E, 16'h906E, 1'b1, 16'h0000, 1'b0);

    // R5 strobes last one cycle, results held
    @(negedge clk);
    chk("R5", "done drop", 32'(done), 0);
    chk("R5", "pass drop", 32'(pass), 0);
    chk("R5", "status hold", 32'(status), 0);
    chk("R5", "calc hold", 32'(calcCheck), 32'h906E);

    // R2 R4 sweep of payload lengths, good then corrupted
    for (int n = 1; n <= 40; n++) begin
      buildImage(n, n, n + 5);
      cv = payloadCheck(n);
      sendImage(1'b0, 1'b0);
      expectResult("R2", cv, cv, 1'b1, 16'h0000, 1'b0);
      img[HDR + (n * 7) % n] ^= 8'(1 << (n % 8));
      cv = payloadCheck(n);
      rxv = {img[HDR+n+1], img[HDR+n]};
      sendImage(1'b0, 1'b0);
      expectResult("R4", cv, rxv, 1'b0, 16'h0001, 1'b0);
    end

    // R4 trailer byte swapped must fail
    buildImage(12, 1, 9);
    cv = payloadCheck(12);
    if (cv[7:0] != cv[15:8]) begin
      img[HDR+12] = cv[15:8];
      img[HDR+13] = cv[7:0];
      sendImage(1'b0, 1'b0);
      expectResult("R4", cv, {cv[7:0], cv[15:8]}, 1'b0, 16'h0001, 1'b0);
    end

    // R1 header content is ignored
    for (int h = 0; h < 6; h++) begin
      buildImage(17, h * 41 + 2, 4);
      cv = payloadCheck(17);
      sendImage(1'b0, 1'b0);
      expectResult("R1", cv, cv, 1'b1, 16'h0000, 1'b0);
    end

    // R7 every short length
    for (int len = 1; len < HDR + 2; len++) begin
      buildImage(4, len, len);
      imgLen = len;
      sendImage(1'b0, 1'b0);
      expectResult("R7", 16'h0000, 16'h0000, 1'b0, 16'hD00B, 1'b1);
    end

    // R6 empty payload
    buildImage(0, 8, 8);
    img[HDR] = 8'h5A;
    img[HDR+1] = 8'hC3;
    sendImage(1'b0, 1'b0);
    expectResult("R6", 16'h0000, 16'hC35A, 1'b0, 16'hD00A, 1'b1);

    // R9 gaps inside the image
    for (int n = 3; n <= 9; n += 3) begin
      buildImage(n, 6, n);
      cv = payloadCheck(n);
      sendImage(1'b1, 1'b0);
      expectResult("R9", cv, cv, 1'b1, 16'h0000, 1'b0);
    end

    // R9 back-to-back, no idle cycle between images
    for (int n = 5; n <= 8; n++) begin
      buildImage(n, 2, n * 3);
      cv = payloadCheck(n);
      for (int i = 0; i < imgLen; i++) begin
        inValid = 1'b1;
        inData = img[i];
        inLast = (i == imgLen - 1);
        @(negedge clk);
      end
      expectResult("R9", cv, cv, 1'b1, 16'h0000, 1'b0);
    end
    inValid = 1'b0;
    inLast = 1'b0;

    // R8 start pulse in an idle cycle drops a partial image
    buildImage(20, 5, 3);
    for (int i = 0; i < HDR + 10; i++) begin
      inValid = 1'b1;
      inData = 8'(i * 3 + 1);
      inLast = 1'b0;
      @(negedge clk);
    end
    inValid = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cv = payloadCheck(20);
    sendImage(1'b0, 1'b0);
    expectResult("R8", cv, cv, 1'b1, 16'h0000, 1'b0);

    // R8 start on the first byte of a new image
    for (int i = 0; i < HDR + 6; i++) begin
      inValid = 1'b1;
      inData = 8'(i ^ 8'hA5);
      inLast = 1'b0;
      @(negedge clk);
    end
    buildImage(15, 7, 11);
    cv = payloadCheck(15);
    sendImage(1'b0, 1'b1);
    expectResult("R8", cv, cv, 1'b1, 16'h0000, 1'b0);

    finishRun();
  end

endmodule